// File: doc/BRIEF.md
# Pin Function and Output Register Block

This block holds the pin-level configuration of a 54-pin general purpose I/O controller. It sits on a plain 32-bit register bus with a byte address, a write strobe, write data and registered read data. For every pin it keeps a 3-bit function code. The code chooses plain input, driven output, or one of six alternate peripheral functions. The block also keeps a one-bit output latch per pin. Software changes a latch only through two registers: one that sets bits where ones are written and one that clears them. This means no read-modify-write sequence is needed when several agents share a bank of pins. A pair of level registers returns the pin inputs after a two-flop synchronizer.

Toward the pad multiplexer the block drives registered per-pin signals: an output enable, the output value, an alternate-function enable and a 3-bit alternate index. A pin leaves its pad undriven in every mode except output. Returning a pin's code to input releases it. The output latch keeps its value across mode changes, so software can preset a level before it turns the driver on.

Top module: `gpio_fn_regs`

## Requirements
- R1: After reset every function code reads 0 (input), every output latch is 0, and pad_oe, pad_out and pad_alt_en are all low.
- R2: Bus word index w = bus_addr[7:2]. Words 0..5 hold the function codes. Pin p sits in word p/10 at bits (p mod 10)*3 +: 3, and a write to a word replaces all of its fields.
- R3: The top two bits of every function word and the fields of pins 54..59 in word 5 read as zero and ignore writes. Level bits for pins 54..63 read as zero.
- R4: A write to word 7 (pins 0..31) or word 8 (pins 32..53) sets the output latch of each pin whose data bit is 1. Pins written with 0 keep their latch.
- R5: A write to word 10 (pins 0..31) or word 11 (pins 32..53) clears the output latch of each pin whose data bit is 1. Pins written with 0 keep their latch.
- R6: Reads of the set and clear words return zero.
- R7: Word 13 (pins 0..31) and word 14 (pins 32..53) return pin_in after a two-flop synchronizer. A change on pin_in shows in a read issued two cycles later.
- R8: One cycle after a function write, pad_oe of a pin is 1 exactly when its code is 1. pad_out always shows the pin's output latch.
- R9: Alternate codes map 4,5,6,7 to alternate index 0,1,2,3, code 3 to index 4 and code 2 to index 5. pad_alt_en is 1 only for codes 2..7, and pad_alt_sel is 0 when pad_alt_en is 0.
- R10: The output latch keeps its value while the pin is in input or alternate mode, and it appears on the pad as soon as the code becomes output.
- R11: Reads of any other word index return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address, low two bits ignored |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the address |
| pin_in | input | 54 | Asynchronous pin input levels |
| pad_oe | output | 54 | Pad output enable per pin |
| pad_out | output | 54 | Pad output value per pin |
| pad_alt_en | output | 54 | Pin is in an alternate function |
| pad_alt_sel | output | 162 | 3-bit alternate index per pin, pin p at bits 3p+:3 |

## Verification
The stimulus is a seeded random mix of function-word writes, set and clear writes with sparse and dense masks, and pin-input changes. After each step the bench compares every pad output and one read-back word against its own model. Using both set and clear masks separates the write-one-only behaviour from a plain overwrite. Directed cases walk all eight codes through one word to pin down the non-linear alternate mapping. Other directed cases write all ones into the partial last function word and the upper bank, which exposes any storage for pins that do not exist. A preset latch followed by a switch to output shows that the latch is held across mode changes.

// File: rtl/gpio_fn_pkg.sv
package gpio_fn_pkg;
  localparam int FN_W = 3;

  typedef enum logic [FN_W-1:0] {
    FN_INPUT  = 3'd0,
    FN_OUTPUT = 3'd1,
    FN_ALT_F  = 3'd2,
    FN_ALT_E  = 3'd3,
    FN_ALT_A  = 3'd4,
    FN_ALT_B  = 3'd5,
    FN_ALT_C  = 3'd6,
    FN_ALT_D  = 3'd7
  } fn_code_e;

  // word indices (byte address / 4)
  localparam int WI_FSEL = 0;
  localparam int WI_SET  = 7;
  localparam int WI_CLR  = 10;
  localparam int WI_LEV  = 13;

  function automatic logic [FN_W-1:0] alt_index(input logic [FN_W-1:0] code);
    if (code[2])               return {1'b0, code[1:0]};
    else if (code == FN_ALT_E) return 3'd4;
    else if (code == FN_ALT_F) return 3'd5;
    else                       return 3'd0;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NUM_PINS = 54
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] lvl_q
);
  logic [NUM_PINS-1:0] meta_q;
  logic [1:0]          age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      lvl_q  <= '0;
      age_q  <= '0;
    end else begin
      meta_q <= pin_in;
      lvl_q  <= meta_q;
      if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end
  end

  // R7
  sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd2) |-> (lvl_q == $past(pin_in, 2)));
endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
  import gpio_fn_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int BUS_W    = 32,
  parameter int WIDX_W   = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [WIDX_W-1:0]        widx,
  input  logic [BUS_W-1:0]         wdata,
  output logic [NUM_PINS*FN_W-1:0] fsel_flat,
  output logic [NUM_PINS-1:0]      lat_q
);
  localparam int PER_WORD = BUS_W / FN_W;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int FREG = p / PER_WORD;
    localparam int FOFF = (p % PER_WORD) * FN_W;
    localparam int BANK = p / BUS_W;
    localparam int BITP = p % BUS_W;
    localparam logic [WIDX_W-1:0] FS_IDX  = WIDX_W'(WI_FSEL + FREG);
    localparam logic [WIDX_W-1:0] SET_IDX = WIDX_W'(WI_SET + BANK);
    localparam logic [WIDX_W-1:0] CLR_IDX = WIDX_W'(WI_CLR + BANK);

    always_ff @(posedge clk) begin
      if (rst) begin
        fsel_flat[p*FN_W +: FN_W] <= FN_INPUT;
        lat_q[p]                  <= 1'b0;
      end else if (we) begin
        if (widx == FS_IDX) fsel_flat[p*FN_W +: FN_W] <= wdata[FOFF +: FN_W];
        if (widx == SET_IDX && wdata[BITP]) lat_q[p] <= 1'b1;
        if (widx == CLR_IDX && wdata[BITP]) lat_q[p] <= 1'b0;
      end
    end
  end

  // R4
  set_bit0_chk: assert property (@(posedge clk) disable iff (rst)
    (we && widx == WIDX_W'(WI_SET) && wdata[0]) |=> lat_q[0]);
  // R5
  clr_bit0_chk: assert property (@(posedge clk) disable iff (rst)
    (we && widx == WIDX_W'(WI_CLR) && wdata[0]) |=> !lat_q[0]);
  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (we && widx == WIDX_W'(WI_CLR) && wdata == '0) |=> $stable(lat_q));
endmodule

// File: rtl/gpio_pad_decode.sv
module gpio_pad_decode
  import gpio_fn_pkg::*;
#(
  parameter int NUM_PINS = 54
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_PINS*FN_W-1:0] fsel_flat,
  input  logic [NUM_PINS-1:0]      lat_q,
  output logic [NUM_PINS-1:0]      pad_oe,
  output logic [NUM_PINS-1:0]      pad_out,
  output logic [NUM_PINS-1:0]      pad_alt_en,
  output logic [NUM_PINS*FN_W-1:0] pad_alt_sel
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
    logic [FN_W-1:0] code;
    logic            is_alt;
    assign code   = fsel_flat[p*FN_W +: FN_W];
    assign is_alt = code[2] | code[1];

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_oe[p]                   <= 1'b0;
        pad_out[p]                  <= 1'b0;
        pad_alt_en[p]               <= 1'b0;
        pad_alt_sel[p*FN_W +: FN_W] <= '0;
      end else begin
        pad_oe[p]                   <= (code == FN_OUTPUT);
        pad_out[p]                  <= lat_q[p];
        pad_alt_en[p]               <= is_alt;
        pad_alt_sel[p*FN_W +: FN_W] <= is_alt ? alt_index(code) : '0;
      end
    end
  end

  // R1
  rst_pads_chk: assert property (@(posedge clk)
    $past(rst) |-> (pad_oe == '0 && pad_alt_en == '0 && pad_out == '0));
  // R8
  oe_alt_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & pad_alt_en) == '0);
endmodule

// File: rtl/gpio_fn_regs.sv
module gpio_fn_regs
  import gpio_fn_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int BUS_W    = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_we,
  input  logic [BUS_W-1:0]         bus_wdata,
  output logic [BUS_W-1:0]         bus_rdata,
  input  logic [NUM_PINS-1:0]      pin_in,
  output logic [NUM_PINS-1:0]      pad_oe,
  output logic [NUM_PINS-1:0]      pad_out,
  output logic [NUM_PINS-1:0]      pad_alt_en,
  output logic [NUM_PINS*FN_W-1:0] pad_alt_sel
);
  localparam int WIDX_W    = ADDR_W - 2;
  localparam int PER_WORD  = BUS_W / FN_W;
  localparam int NUM_FS    = (NUM_PINS + PER_WORD - 1) / PER_WORD;
  localparam int NUM_BANKS = (NUM_PINS + BUS_W - 1) / BUS_W;

  logic [WIDX_W-1:0]        widx;
  logic [NUM_PINS*FN_W-1:0] fsel_flat;
  logic [NUM_PINS-1:0]      lat_q;
  logic [NUM_PINS-1:0]      lvl_q;
  logic [NUM_BANKS*BUS_W-1:0] lvl_pad;
  logic [BUS_W-1:0]         fs_word [NUM_FS];
  logic [BUS_W-1:0]         rd_next;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign lvl_pad = {{(NUM_BANKS*BUS_W-NUM_PINS){1'b0}}, lvl_q};

  gpio_in_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in), .lvl_q(lvl_q));

  gpio_pin_cfg #(.NUM_PINS(NUM_PINS), .BUS_W(BUS_W), .WIDX_W(WIDX_W)) u_cfg (
    .clk(clk), .rst(rst), .we(bus_we), .widx(widx), .wdata(bus_wdata),
    .fsel_flat(fsel_flat), .lat_q(lat_q));

  gpio_pad_decode #(.NUM_PINS(NUM_PINS)) u_pad (
    .clk(clk), .rst(rst), .fsel_flat(fsel_flat), .lat_q(lat_q),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_alt_en(pad_alt_en),
    .pad_alt_sel(pad_alt_sel));

  always_comb begin
    for (int k = 0; k < NUM_FS; k++) begin
      fs_word[k] = '0;
      for (int j = 0; j < PER_WORD; j++) begin
        if (k * PER_WORD + j < NUM_PINS)
          fs_word[k][j*FN_W +: FN_W] = fsel_flat[(k*PER_WORD+j)*FN_W +: FN_W];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < NUM_FS; k++)
      if (widx == WIDX_W'(WI_FSEL + k)) rd_next = fs_word[k];
    for (int b = 0; b < NUM_BANKS; b++)
      if (widx == WIDX_W'(WI_LEV + b)) rd_next = lvl_pad[b*BUS_W +: BUS_W];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  // R6
  set_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (widx == WIDX_W'(WI_SET) || widx == WIDX_W'(WI_CLR)) |=> (bus_rdata == '0));
  // R3
  fs_top_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (widx < WIDX_W'(NUM_FS)) |=> (bus_rdata[BUS_W-1:PER_WORD*FN_W] == '0));
endmodule

// File: tb/test_gpio_fn_regs.sv
module test_gpio_fn_regs;
  localparam int NP = 54;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [7:0]   bus_addr = '0;
  logic         bus_we = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pad_oe, pad_out, pad_alt_en;
  logic [NP*3-1:0] pad_alt_sel;

  int checks = 0;
  int errors = 0;

  logic [2:0] m_fsel [NP];
  logic       m_lat  [NP];

  always #5 clk = ~clk;

  gpio_fn_regs i_gpio_fn_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_alt_en(pad_alt_en),
    .pad_alt_sel(pad_alt_sel));

  function automatic logic [2:0] exp_alt(input logic [2:0] c);
    case (c)
      3'd4: return 3'd0; 3'd5: return 3'd1; 3'd6: return 3'd2;
      3'd7: return 3'd3; 3'd3: return 3'd4; 3'd2: return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [31:0] exp_word(input int w);
    logic [31:0] r = '0;
    if (w < 6) begin
      for (int j = 0; j < 10; j++)
        if (w*10 + j < NP) r[j*3 +: 3] = m_fsel[w*10 + j];
    end else if (w == 13 || w == 14) begin
      for (int i = 0; i < 32; i++)
        if ((w-13)*32 + i < NP) r[i] = pin_in[(w-13)*32 + i];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    int w = int'(a[7:2]);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    if (w < 6) begin
      for (int j = 0; j < 10; j++)
        if (w*10 + j < NP) m_fsel[w*10 + j] = d[j*3 +: 3];
    end else if (w == 7 || w == 8) begin
      for (int i = 0; i < 32; i++)
        if ((w-7)*32 + i < NP && d[i]) m_lat[(w-7)*32 + i] = 1'b1;
    end else if (w == 10 || w == 11) begin
      for (int i = 0; i < 32; i++)
        if ((w-10)*32 + i < NP && d[i]) m_lat[(w-10)*32 + i] = 1'b0;
    end
  endtask

  task automatic read_check(input string tag, input logic [7:0] a);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    check(tag, bus_rdata, exp_word(int'(a[7:2])));
  endtask

  task automatic pads_check(input string tag);
    int bad = 0;
    logic [31:0] act = '0, exp = '0;
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      logic [2:0] c = m_fsel[p];
      logic ae = (c >= 3'd2);
      logic [5:0] e = {ae ? exp_alt(c) : 3'd0, ae, m_lat[p], c == 3'd1};
      logic [5:0] g = {pad_alt_sel[p*3 +: 3], pad_alt_en[p], pad_out[p], pad_oe[p]};
      if (g !== e && bad == 0) begin
        bad = 1; act = {26'd0, g}; exp = {26'd0, e};
        $display("pin %0d", p);
      end
    end
    check(tag, act, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int p = 0; p < NP; p++) begin m_fsel[p] = 3'd0; m_lat[p] = 1'b0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    pads_check("R1 reset pads");
    for (int w = 0; w < 6; w++) read_check("R1 reset function word", 8'(w*4));

    // R9 all eight codes on pins 0..7
    do_write(8'h00, {8'd0, 3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0});
    pads_check("R9 alternate mapping");
    read_check("R2 word 0 readback", 8'h00);

    // R3 partial last word, unused top bits
    do_write(8'h14, 32'hFFFF_FFFF);
    read_check("R3 word 5 only pins 50..53", 8'h14);
    check("R3 word 5 value", exp_word(5), 32'h0000_0FFF);
    do_write(8'h04, 32'hFFFF_FFFF);
    read_check("R3 top bits of word 1", 8'h04);

    // R10 preset latch while input, then switch to output
    do_write(8'h00, 32'h0);
    do_write(8'h1C, 32'h0000_0001);
    pads_check("R10 latch held while input");
    do_write(8'h00, 32'h0000_0001);
    pads_check("R10 preset latch appears on output");
    do_write(8'h00, 32'h0000_0004);
    pads_check("R10 latch kept in alternate mode");

    // R4 R5 zero writes, R6 reads of set/clear
    do_write(8'h1C, 32'h0);
    do_write(8'h28, 32'h0);
    pads_check("R4 R5 zero write no effect");
    read_check("R6 set word reads zero", 8'h1C);
    read_check("R6 clear word reads zero", 8'h2C);

    // R3 R7 upper bank levels
    @(negedge clk); pin_in = '1;
    repeat (2) @(negedge clk);
    read_check("R7 level bank 1", 8'h38);
    check("R3 level bank 1 value", exp_word(14), 32'h003F_FFFF);

    // R11 unmapped words
    do_write(8'h18, 32'hFFFF_FFFF);
    read_check("R11 unmapped word 6", 8'h18);
    pads_check("R11 unmapped write no effect");
    read_check("R11 unmapped word 15", 8'h3C);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom % 4);
      case (op)
        0: do_write(8'(($urandom % 6) * 4), $urandom);
        1: do_write(8'((7 + $urandom % 2) * 4), $urandom & $urandom);
        2: do_write(8'((10 + $urandom % 2) * 4), $urandom | $urandom);
        default: begin
          @(negedge clk); pin_in = {$urandom, $urandom};
          repeat (2) @(negedge clk);
          read_check("R7 random level", 8'((13 + $urandom % 2) * 4));
        end
      endcase
      if (op == 1)      pads_check("R4 random set");
      else if (op == 2) pads_check("R5 random clear");
      else              pads_check("R8 random pads");
      read_check("R2 random readback", 8'(($urandom % 6) * 4));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule